// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset cause on the chip into one synchronous system reset. The causes are a power-on level, a brown-out level with an enable, an active-low external reset pin, a watchdog timeout, a software reset strobe, a trap-conflict lockup and an illegal-instruction or bad-pointer fault. The external pin first passes through a two-stage synchronizer and a digital glitch filter. A low pulse shorter than the filter length is ignored. The pin is an input only, and no internal cause drives it.

The reset output behaves like a set/reset latch. Any active cause sets it. A hold counter clears it a fixed number of clocks after the last cause goes away. A watchdog timeout while the core is in sleep or idle does not reset anything. It produces a one-clock wake-up pulse instead. Eight sticky status flags record which causes fired. Software reads them and clears any of them by writing ones to the clear strobe. Power-on initializes the flags.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `por_det` is high, `sys_rst` is high and `flags` equals 8'h03, with only the power-on flag (bit 0) and the brown-out flag (bit 1) set.
- R2: A low pulse on `ext_rst_n` lasting fewer than FILT_CYCLES (default 4) clocks is ignored. It causes no reset and sets no flag.
- R3: `ext_rst_n` held low long enough to pass the synchronizer and the filter asserts `sys_rst` and sets the pin flag (bit 2). If `sleep_mode` is high at the same time, the sleep flag (bit 7) is also set.
- R4: `wdt_timeout` with `sleep_mode` low asserts `sys_rst` and sets the watchdog flag (bit 3).
- R5: `wdt_timeout` with `sleep_mode` high does not assert `sys_rst`. It drives `wdt_wake` high on the following clock and sets bits 3 and 7.
- R6: `bor_det` asserts `sys_rst` and sets only bit 1 when `bor_en` is high. When `bor_en` is low, `bor_det` has no effect.
- R7: `sw_reset` sets bit 4, `trap_lockup` sets bit 5 and `illegal_op` sets bit 6. Each of these also asserts `sys_rst`.
- R8: After every cause has deasserted, `sys_rst` stays high for HOLD_CYCLES (default 8) more clocks and then falls.
- R9: A flag stays set until its `flag_clr` bit is pulsed, or until power-on. A cause of another kind never clears it. If a set and a clear hit the same flag in the same cycle, the set wins.
- R10: `sys_rst` rises on the first clock edge that samples an active cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_det | input | 1 | Power-on detect level, active high |
| bor_det | input | 1 | Brown-out detect level, active high |
| bor_en | input | 1 | Brown-out reset enable |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_timeout | input | 1 | Watchdog timeout strobe |
| sw_reset | input | 1 | Software reset instruction strobe |
| trap_lockup | input | 1 | Trap-conflict lockup indication |
| illegal_op | input | 1 | Illegal opcode or invalid pointer fault |
| sleep_mode | input | 1 | Core is in sleep or idle |
| flag_clr | input | 8 | Write-one-to-clear strobe per status flag |
| sys_rst | output | 1 | Synchronous system reset, active high |
| wdt_wake | output | 1 | Watchdog wake-up pulse |
| flags | output | 8 | Sticky cause flags (0 por, 1 bor, 2 pin, 3 wdt, 4 sw, 5 trap, 6 illegal, 7 sleep) |

## Verification
Two cases are hard to reach from the ports. One is the filter boundary: the pin is low for just under the filter length, so the count climbs to its limit minus one and then falls back with no reset. The other is the split between sleep and run for one and the same cause. Each vector therefore first clears all flags, then sets `sleep_mode` before driving the watchdog or the pin, and reads the flags only after the reset has been released. The release timing is checked on the exact clocks on both sides of the hold boundary. The set-over-clear race is driven by pulsing a cause and its clear bit in the same cycle.

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl #(
  parameter int FILT_CYCLES = 4,
  parameter int HOLD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       por_det,
  input  logic       bor_det,
  input  logic       bor_en,
  input  logic       ext_rst_n,
  input  logic       wdt_timeout,
  input  logic       sw_reset,
  input  logic       trap_lockup,
  input  logic       illegal_op,
  input  logic       sleep_mode,
  input  logic [7:0] flag_clr,
  output logic       sys_rst,
  output logic       wdt_wake,
  output logic [7:0] flags
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES);

  logic [1:0]    pin_sq;
  logic [FW-1:0] low_cnt;
  logic [HW-1:0] hold_cnt;

  wire pin_rst = (low_cnt == FW'(FILT_CYCLES));
  wire bor_hit = bor_det & bor_en;
  wire wdt_run = wdt_timeout & ~sleep_mode;
  wire any_src = por_det | bor_hit | pin_rst | wdt_run | sw_reset | trap_lockup | illegal_op;
  wire [7:0] set_vec = {(pin_rst | wdt_timeout) & sleep_mode, illegal_op, trap_lockup,
                        sw_reset, wdt_timeout, pin_rst, bor_hit, 1'b0};

  always_ff @(posedge clk) begin
    if (por_det) begin
      pin_sq  <= 2'b11;
      low_cnt <= '0;
    end else begin
      pin_sq <= {pin_sq[0], ext_rst_n};
      if (pin_sq[1])     low_cnt <= '0;
      else if (!pin_rst) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (any_src) begin
      sys_rst  <= 1'b1;
      hold_cnt <= '0;
    end else if (sys_rst) begin
      if (hold_cnt == HW'(HOLD_CYCLES - 1)) sys_rst <= 1'b0;
      else                                  hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por_det) begin
      flags    <= 8'h03;
      wdt_wake <= 1'b0;
    end else begin
      flags    <= (flags & ~flag_clr) | set_vec;
      wdt_wake <= wdt_timeout & sleep_mode;
    end
  end
endmodule

// File: rtl/sys_reset_ctrl_chk.sv
module sys_reset_ctrl_chk (
  input logic       clk,
  input logic       por_det,
  input logic       bor_det,
  input logic       bor_en,
  input logic       wdt_timeout,
  input logic       sw_reset,
  input logic       trap_lockup,
  input logic       illegal_op,
  input logic       sleep_mode,
  input logic [7:0] flag_clr,
  input logic       sys_rst,
  input logic       wdt_wake,
  input logic [7:0] flags
);
  a_r10_direct_src_resets: assert property (@(posedge clk) disable iff (por_det)
    (sw_reset || trap_lockup || illegal_op) |=> sys_rst);

  a_r5_sleep_wdt_wakes: assert property (@(posedge clk) disable iff (por_det)
    (wdt_timeout && sleep_mode) |=> wdt_wake);

  a_r8_no_release_while_src: assert property (@(posedge clk) disable iff (por_det)
    $fell(sys_rst) |-> !$past(sw_reset || trap_lockup || illegal_op));

  a_r6_bor_flag_needs_enable: assert property (@(posedge clk) disable iff (por_det)
    $rose(flags[1]) |-> $past(bor_det && bor_en));

  for (genvar i = 0; i < 8; i++) begin : g_sticky
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (por_det)
      (flags[i] && !flag_clr[i]) |=> flags[i]);
  end
endmodule

bind sys_reset_ctrl sys_reset_ctrl_chk u_chk (
  .clk(clk), .por_det(por_det), .bor_det(bor_det), .bor_en(bor_en),
  .wdt_timeout(wdt_timeout), .sw_reset(sw_reset), .trap_lockup(trap_lockup),
  .illegal_op(illegal_op), .sleep_mode(sleep_mode), .flag_clr(flag_clr),
  .sys_rst(sys_rst), .wdt_wake(wdt_wake), .flags(flags)
);

// File: tb/sys_reset_ctrl_tb.sv
module sys_reset_ctrl_tb;
  logic clk = 1'b0;
  logic por_det = 1'b1, bor_det = 1'b0, bor_en = 1'b0, ext_rst_n = 1'b1;
  logic wdt_timeout = 1'b0, sw_reset = 1'b0, trap_lockup = 1'b0, illegal_op = 1'b0;
  logic sleep_mode = 1'b0;
  logic [7:0] flag_clr = 8'h00;
  logic sys_rst, wdt_wake;
  logic [7:0] flags;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sys_reset_ctrl u_dut (.*);

  // {src[3:0], sleep, exp_rst, exp_wake, 1'b0, exp_flags[7:0]}
  // src: 1 sw, 2 trap, 3 illegal, 4 wdt, 5 bor enabled, 6 bor disabled, 7 pin long, 8 pin short
  localparam logic [15:0] VEC [10] = '{
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10},  // R7
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h20},  // R7
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h40},  // R7
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08},  // R4
    {4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 8'h88},  // R5
    {4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02},  // R6
    {4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R6
    {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 8'h04},  // R3
    {4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 8'h84},  // R3
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}   // R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_all();
    flag_clr = 8'hFF;
    @(negedge clk);
    flag_clr = 8'h00;
    @(negedge clk);
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    case (src)
      1: sw_reset = 1'b1;
      2: trap_lockup = 1'b1;
      3: illegal_op = 1'b1;
      4: wdt_timeout = 1'b1;
      5: begin bor_en = 1'b1; bor_det = 1'b1; end
      default: begin bor_en = 1'b0; bor_det = 1'b1; end
    endcase
    @(negedge clk);
    {sw_reset, trap_lockup, illegal_op, wdt_timeout, bor_det, bor_en} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rst during por", {7'd0, sys_rst}, 8'h01);
    check("R1 flags during por", flags, 8'h03);
    por_det = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 released after por", {7'd0, sys_rst}, 8'h00);
    check("R1 flags kept after por", flags, 8'h03);
    clear_all();
    check("R9 clear all", flags, 8'h00);

    for (int i = 0; i < 10; i++) begin
      logic [15:0] v;
      v = VEC[i];
      sleep_mode = v[11];
      if (v[15:12] >= 4'd7) begin
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (v[15:12] == 4'd7 ? 12 : 3) @(negedge clk);
        if (v[15:12] == 4'd8) ext_rst_n = 1'b1;
        repeat (v[15:12] == 4'd8 ? 8 : 0) @(negedge clk);
        check($sformatf("R3/R2 rst vec %0d", i), {7'd0, sys_rst}, {7'd0, v[10]});
        ext_rst_n = 1'b1;
      end else begin
        pulse(int'(v[15:12]));
        check($sformatf("R10 rst vec %0d", i), {7'd0, sys_rst}, {7'd0, v[10]});
        check($sformatf("R5 wake vec %0d", i), {7'd0, wdt_wake}, {7'd0, v[9]});
      end
      sleep_mode = 1'b0;
      repeat (16) @(negedge clk);
      check($sformatf("R8 released vec %0d", i), {7'd0, sys_rst}, 8'h00);
      check($sformatf("R9 flags vec %0d", i), flags, v[7:0]);
      clear_all();
    end

    // R8 exact release edge
    pulse(1);
    check("R10 rst on first edge", {7'd0, sys_rst}, 8'h01);
    repeat (7) @(negedge clk);
    check("R8 still held at hold end", {7'd0, sys_rst}, 8'h01);
    @(negedge clk);
    check("R8 released after hold", {7'd0, sys_rst}, 8'h00);

    // R9 sticky across other causes, selective clear
    pulse(2);
    repeat (12) @(negedge clk);
    check("R9 sticky across cause", flags, 8'h30);
    flag_clr = 8'h10;
    @(negedge clk);
    flag_clr = 8'h00;
    @(negedge clk);
    check("R9 selective clear", flags, 8'h20);

    // R9 set wins over clear
    sw_reset = 1'b1;
    flag_clr = 8'h10;
    @(negedge clk);
    sw_reset = 1'b0;
    flag_clr = 8'h00;
    @(negedge clk);
    check("R9 set beats clear", flags, 8'h30);

    // R1 power-on reinitializes flags
    repeat (12) @(negedge clk);
    por_det = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 por reinit flags", flags, 8'h03);
    check("R1 por asserts rst", {7'd0, sys_rst}, 8'h01);
    por_det = 1'b0;
    repeat (12) @(negedge clk);
    check("R1 flags after por", flags, 8'h03);

    finish_run();
  end
endmodule